// File: doc/BRIEF.md
# Predicated Vector Lane Execution Unit

This block applies one two-operand integer operation to every element of a wide vector register. The vector width `VLEN` is a parameter (256 bits by default). Each request picks its own element width of 8, 16, 32 or 64 bits, so the vector splits into `VLEN/8`, `VLEN/16`, `VLEN/32` or `VLEN/64` independent lanes. No carry or borrow passes from one lane to the next.

A byte-granular predicate decides which lanes take part. The predicate has one bit for each byte of the vector. For a given lane, only the predicate bit of its lowest byte matters. An active lane receives the operation result. An inactive lane receives either zero or the lane's value from the prior destination operand, as chosen by a per-request merge control. The result is registered and appears one clock after the request strobe, with a matching valid flag.

Top module: `pvx_exec_unit`

## Requirements
- R1: `VLEN` must be a multiple of 128 in the range 128 to 2048, and any other value stops elaboration. The predicate port is `VLEN/8` bits wide, one bit per vector byte.
- R2: The element width code `esize_i` gives the lane width: 2'b00 is 8 bits, 2'b01 is 16, 2'b10 is 32 and 2'b11 is 64. Lane k occupies bits `[k*W +: W]` of every vector operand.
- R3: A lane of W bits covers W/8 predicate bits starting at bit k*W/8. The lane is active exactly when that lowest bit is 1. Its other predicate bits have no effect on the result.
- R4: Op code 4'd0 gives a+b and op code 4'd1 gives a-b. Both wrap modulo 2^W, with no carry or borrow crossing into a neighbouring lane.
- R5: With `merge_i`=0 (zeroing), every bit of an inactive lane's result is 0.
- R6: With `merge_i`=1 (merging), an inactive lane's result equals the same lane of `dst_i`.
- R7: Op codes 4'd2, 4'd3 and 4'd4 give bitwise AND, OR and XOR. Any op code above 4'd8 gives zero in active lanes.
- R8: Op codes 4'd5 and 4'd6 give signed minimum and signed maximum, comparing lanes as two's complement. Op codes 4'd7 and 4'd8 give unsigned minimum and unsigned maximum.
- R9: `out_vec_o` and `out_valid_o` update on the clock edge that samples `in_valid_i`=1. In a cycle without `in_valid_i`, `out_valid_o` drops to 0 and `out_vec_o` holds its value. A synchronous reset clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| esize_i | input | 2 | Element width code |
| merge_i | input | 1 | 1 merges inactive lanes from dst_i, 0 zeroes them |
| src_a_i | input | VLEN | First source vector |
| src_b_i | input | VLEN | Second source vector |
| dst_i | input | VLEN | Prior destination value |
| pred_i | input | VLEN/8 | Byte-granular predicate |
| out_vec_o | output | VLEN | Registered result vector |
| out_valid_o | output | 1 | Result valid, one cycle after the request |

## Verification
The bench builds the unit with `VLEN`=256. This gives four 64-bit slices and 32 predicate bits, so that every element width has several lanes. Carries that would leak across lane and slice boundaries therefore become visible. The predicate patterns set only the non-lowest bits of a lane, or alternate lanes, which exercises the lowest-bit rule at every width. A reference model written separately in the bench produces the expected vectors for each operation, width and inactive-lane mode.

// File: rtl/pvx_pkg.sv
package pvx_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SMIN = 4'd5,
        OP_SMAX = 4'd6,
        OP_UMIN = 4'd7,
        OP_UMAX = 4'd8
    } pvx_op_e;

    typedef enum logic [1:0] {
        ES_8  = 2'b00,
        ES_16 = 2'b01,
        ES_32 = 2'b10,
        ES_64 = 2'b11
    } pvx_es_e;

    localparam int SLICE_W = 64;
endpackage

// File: rtl/pvx_lane_mask.sv
// Expands the byte predicate into a per-byte enable: each byte copies the
// predicate bit at the lowest byte of the lane it belongs to.
module pvx_lane_mask #(
    parameter int PW = 32
) (
    input  logic [PW-1:0] pred_i,
    input  logic [1:0]    esize_i,
    output logic [PW-1:0] byte_en_o
);
    always_comb begin
        for (int j = 0; j < PW; j++) begin
            int lane_bytes;
            int base;
            lane_bytes   = 1 << esize_i;
            base         = j - (j % lane_bytes);
            byte_en_o[j] = pred_i[base];
        end
    end
endmodule

// File: rtl/pvx_slice_alu.sv
// One 64-bit slice: computes the result for every element width, then picks one.
module pvx_slice_alu
    import pvx_pkg::*;
(
    input  logic [SLICE_W-1:0] a_i,
    input  logic [SLICE_W-1:0] b_i,
    input  logic [3:0]         op_i,
    input  logic [1:0]         esize_i,
    output logic [SLICE_W-1:0] res_o
);
    logic [3:0][SLICE_W-1:0] res_by_es;

    for (genvar g = 0; g < 4; g++) begin : g_es
        localparam int W = 8 << g;
        localparam int N = SLICE_W / W;
        for (genvar e = 0; e < N; e++) begin : g_el
            logic [W-1:0] x_d;
            logic [W-1:0] y_d;
            logic [W-1:0] r_d;
            assign x_d = a_i[e*W +: W];
            assign y_d = b_i[e*W +: W];
            always_comb begin
                case (op_i)
                    OP_ADD:  r_d = x_d + y_d;
                    OP_SUB:  r_d = x_d - y_d;
                    OP_AND:  r_d = x_d & y_d;
                    OP_OR:   r_d = x_d | y_d;
                    OP_XOR:  r_d = x_d ^ y_d;
                    OP_SMIN: r_d = ($signed(x_d) < $signed(y_d)) ? x_d : y_d;
                    OP_SMAX: r_d = ($signed(x_d) > $signed(y_d)) ? x_d : y_d;
                    OP_UMIN: r_d = (x_d < y_d) ? x_d : y_d;
                    OP_UMAX: r_d = (x_d > y_d) ? x_d : y_d;
                    default: r_d = '0;
                endcase
            end
            assign res_by_es[g][e*W +: W] = r_d;
        end
    end

    assign res_o = res_by_es[esize_i];
endmodule

// File: rtl/pvx_exec_unit.sv
module pvx_exec_unit
    import pvx_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid_i,
    input  logic [3:0]        op_i,
    input  logic [1:0]        esize_i,
    input  logic              merge_i,
    input  logic [VLEN-1:0]   src_a_i,
    input  logic [VLEN-1:0]   src_b_i,
    input  logic [VLEN-1:0]   dst_i,
    input  logic [VLEN/8-1:0] pred_i,
    output logic [VLEN-1:0]   out_vec_o,
    output logic              out_valid_o
);
    localparam int PW = VLEN / 8;
    localparam int NS = VLEN / SLICE_W;

    // R1: legal vector lengths only
    if ((VLEN % 128) != 0 || VLEN < 128 || VLEN > 2048) begin : g_bad_vlen
        $error("pvx_exec_unit: VLEN must be a multiple of 128 within 128..2048");
    end

    typedef struct packed {
        logic            valid;
        logic [VLEN-1:0] vec;
    } state_t;

    state_t          st_d;
    state_t          st_q;
    logic [PW-1:0]   byte_en;
    logic [VLEN-1:0] alu_res;

    pvx_lane_mask #(.PW(PW)) mask_i (
        .pred_i    (pred_i),
        .esize_i   (esize_i),
        .byte_en_o (byte_en)
    );

    for (genvar s = 0; s < NS; s++) begin : g_slice
        pvx_slice_alu alu_i (
            .a_i     (src_a_i[s*SLICE_W +: SLICE_W]),
            .b_i     (src_b_i[s*SLICE_W +: SLICE_W]),
            .op_i    (op_i),
            .esize_i (esize_i),
            .res_o   (alu_res[s*SLICE_W +: SLICE_W])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid_i;
        if (in_valid_i) begin
            for (int j = 0; j < PW; j++) begin
                if (byte_en[j]) begin
                    st_d.vec[j*8 +: 8] = alu_res[j*8 +: 8];
                end else if (merge_i) begin
                    st_d.vec[j*8 +: 8] = dst_i[j*8 +: 8];
                end else begin
                    st_d.vec[j*8 +: 8] = 8'h00;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vec_o   = st_q.vec;
    assign out_valid_o = st_q.valid;

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> out_valid_o) else $error("valid not raised"); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> (!out_valid_o && $stable(out_vec_o))) else $error("idle changed output"); // R9
    AST_ZERO_LANE: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && !merge_i && esize_i == 2'b00 && !pred_i[0])
        |=> (out_vec_o[7:0] == 8'h00)) else $error("inactive lane not zero"); // R5
    AST_MERGE_LANE: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && merge_i && esize_i == 2'b11 && !pred_i[0])
        |=> (out_vec_o[63:0] == $past(dst_i[63:0]))) else $error("inactive lane not merged"); // R6
    AST_AND_LANE: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && op_i == 4'd2 && esize_i == 2'b00 && pred_i[0])
        |=> (out_vec_o[7:0] == ($past(src_a_i[7:0]) & $past(src_b_i[7:0])))) else $error("and lane wrong"); // R7
endmodule

// File: tb/pvx_exec_unit_tb_top.sv
module pvx_exec_unit_tb_top;
    localparam int VL = 256;
    localparam int PW = VL / 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [3:0]    op;
    logic [1:0]    es;
    logic          merge;
    logic [VL-1:0] a, b, d;
    logic [PW-1:0] p;
    logic [VL-1:0] out_vec;
    logic          out_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pvx_exec_unit #(.VLEN(VL)) dut_i (
        .clk(clk), .rst(rst), .in_valid_i(in_valid), .op_i(op), .esize_i(es),
        .merge_i(merge), .src_a_i(a), .src_b_i(b), .dst_i(d), .pred_i(p),
        .out_vec_o(out_vec), .out_valid_o(out_valid)
    );

    function automatic logic [VL-1:0] model(input logic [VL-1:0] ma, mb, md,
                                             input logic [PW-1:0] mp,
                                             input logic [1:0] mes, input logic [3:0] mop,
                                             input logic mmerge);
        logic [VL-1:0] res = '0;
        int lw = 8 << mes;
        logic [63:0] msk = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 1);
        for (int i = 0; i < VL / lw; i++) begin
            logic [63:0] x = 64'(ma >> (i * lw)) & msk;
            logic [63:0] y = 64'(mb >> (i * lw)) & msk;
            logic [63:0] z = 64'(md >> (i * lw)) & msk;
            logic signed [63:0] sx = $signed(x << (64 - lw));
            logic signed [63:0] sy = $signed(y << (64 - lw));
            logic [63:0] r;
            case (mop)
                4'd0: r = x + y;
                4'd1: r = x - y;
                4'd2: r = x & y;
                4'd3: r = x | y;
                4'd4: r = x ^ y;
                4'd5: r = (sx < sy) ? x : y;
                4'd6: r = (sx > sy) ? x : y;
                4'd7: r = (x < y) ? x : y;
                4'd8: r = (x > y) ? x : y;
                default: r = 64'd0;
            endcase
            if (!mp[i * (lw / 8)]) r = mmerge ? z : 64'd0;
            res = res | (VL'(r & msk) << (i * lw));
        end
        return res;
    endfunction

    task automatic check_vec(input string req, input logic [VL-1:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive one request at a negedge, sample the registered result one cycle later
    task automatic run_op(input string req, input logic [3:0] o, input logic [1:0] e,
                          input logic m, input logic [PW-1:0] pp);
        @(negedge clk);
        op = o; es = e; merge = m; p = pp; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit(req, out_valid, 1'b1);
        check_vec(req, out_vec, model(a, b, d, pp, e, o, m));
    endtask

    task automatic t_reset();
        check_bit("R9 reset valid", out_valid, 1'b0);
        check_vec("R9 reset vec", out_vec, '0);
        check_bit("R1 pred width", ($bits(p) == VL / 8), 1'b1);
    endtask

    task automatic t_arith();
        a = {32{8'hFF}}; b = {32{8'h01}}; d = '0;
        for (int e = 0; e < 4; e++) run_op("R4 add wrap", 4'd0, 2'(e), 1'b0, '1);
        a = '0; b = {32{8'h01}};
        for (int e = 0; e < 4; e++) run_op("R4 sub borrow", 4'd1, 2'(e), 1'b0, '1);
        a = {8{32'h1234_89AB}}; b = {8{32'hFEDC_7F65}};
        for (int e = 0; e < 4; e++) run_op("R2 lane width add", 4'd0, 2'(e), 1'b0, '1);
    endtask

    task automatic t_logic();
        a = {8{32'hF0F0_AA55}}; b = {8{32'h0FF0_5A3C}};
        run_op("R7 and", 4'd2, 2'b00, 1'b0, '1);
        run_op("R7 or",  4'd3, 2'b01, 1'b0, '1);
        run_op("R7 xor", 4'd4, 2'b10, 1'b0, '1);
        run_op("R7 undefined op", 4'd12, 2'b11, 1'b0, '1);
    endtask

    task automatic t_minmax();
        a = {16{16'h807F}}; b = {16{16'h7F80}};
        for (int o = 5; o <= 8; o++) begin
            run_op("R8 minmax 8", 4'(o), 2'b00, 1'b0, '1);
            run_op("R8 minmax 16", 4'(o), 2'b01, 1'b0, '1);
        end
        a = {4{64'h8000_0000_0000_0001}}; b = {4{64'h0000_0000_0000_0002}};
        run_op("R8 smin 64", 4'd5, 2'b11, 1'b0, '1);
        run_op("R8 umax 64", 4'd8, 2'b11, 1'b0, '1);
    endtask

    task automatic t_pred();
        a = {8{32'h1111_2222}}; b = {8{32'h0101_0303}}; d = {8{32'hDEAD_BEEF}};
        run_op("R5 zeroing alt lanes", 4'd0, 2'b00, 1'b0, {16{2'b01}});
        run_op("R6 merging alt lanes", 4'd0, 2'b01, 1'b1, {8{4'b0011}});
        run_op("R6 merging 64", 4'd1, 2'b11, 1'b1, 32'h0000_FF01);
        // only non-lowest predicate bits set: every wide lane inactive
        run_op("R3 upper bits ignored 64", 4'd0, 2'b11, 1'b0, {4{8'hFE}});
        run_op("R3 upper bits ignored 32", 4'd0, 2'b10, 1'b1, {8{4'hE}});
        run_op("R3 lowest bit only 16", 4'd4, 2'b01, 1'b0, {16{2'b01}});
    endtask

    task automatic t_hold();
        logic [VL-1:0] last;
        last = out_vec;
        a = ~a;
        @(negedge clk);
        check_bit("R9 idle valid low", out_valid, 1'b0);
        check_vec("R9 idle hold", out_vec, last);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_vec("R9 reset clears", out_vec, '0);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = '0; es = '0; merge = 1'b0;
        a = '0; b = '0; d = '0; p = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_arith();
        t_logic();
        t_minmax();
        t_pred();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule